// File: doc/BRIEF.md
# Two-Arm Intersection Lamp Sequencer

This block steps the lamps of a crossing where two roads meet. Each road (an arm) gets a through-and-right green and then its own protected left-turn interval, shown as a red lamp with a left arrow. The block moves out of a green, left-arrow or walk interval only when a separate timing block raises a switch request. It never decides when to switch. Its job is to keep the lamp sequence safe and in a fixed order.

Every departure from a green or left-arrow interval goes through a yellow interval on the same arm. The yellow interval lasts exactly two pulses of a slow tick input. A pedestrian button press is captured and held. The walk interval, in which both arms show red, is added only once the whole cycle of both arms has completed. The block reports the active arm and the phase code, and it raises a one-cycle pulse whenever the phase changes. The timing block uses that pulse to restart its own interval timer.

Top module: `tlPhaseSeq`

## Requirements
- R1: While reset is low and right after it is released, arm 1 is green and arm 2 is red. Walk is low, activeArm is 0, phaseCode is 0, phaseChange is low, and no pedestrian request is pending.
- R2: At most one arm shows green or a left arrow at any time. At least one arm shows red at all times, and every arm other than the active one shows red.
- R3: In a green, left-arrow or walk interval, the lamps, activeArm and phaseCode do not change while swReq is low. The tick and button inputs do not change them either.
- R4: A yellow interval ends on the second tick pulse after it is entered, no matter how many clock cycles lie between the pulses. The tick count starts from zero on entry, and swReq has no effect during yellow.
- R5: When swReq is high in a green or left-arrow interval, the next cycle shows yellow on the same arm. The fixed order is: arm 1 green, yellow, arm 1 left arrow, yellow, arm 2 green, yellow, arm 2 left arrow, yellow, and then arm 1 green again.
- R6: A rising edge on pedButton latches one pedestrian request. A button held high counts as one press. A pending request adds a walk interval only after the yellow that follows arm 2's left arrow. Serving the walk interval clears the request, so the following cycle has no walk interval.
- R7: During the walk interval both arms show red only and walk is high. The interval ends on swReq and returns to arm 1 green.
- R8: phaseChange is high for exactly the first clock cycle of every new phase, and low at all other times.
- R9: Encodings: phaseCode 0 = green, 1 = left arrow, 2 = yellow, 3 = walk. activeArm 0 = arm 1 and 1 = arm 2, and it stays 1 during walk. Bit i of each lamp vector belongs to arm i+1. In a left-arrow interval the arm's red and left lamps are both lit. In green or yellow only that colour is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow time-base pulse used to time yellow |
| swReq | input | 1 | Switch request from the timing block |
| pedButton | input | 1 | Raw pedestrian button level |
| lampRed | output | 2 | Red lamp per arm |
| lampYellow | output | 2 | Yellow lamp per arm |
| lampGreen | output | 2 | Green (through and right) lamp per arm |
| lampLeft | output | 2 | Left-turn arrow per arm |
| walk | output | 1 | Pedestrian walk signal |
| activeArm | output | 1 | Arm currently served |
| phaseCode | output | 2 | Current phase code |
| phaseChange | output | 1 | One-cycle pulse on each phase change |

## Verification
The bench drives full cycles in three ways: with no button press, with one press held high for several cycles during arm 1 green, and with switch requests and ticks arriving when they should have no effect. The run without a press shows that the cycle order is correct and that no walk interval appears. The held press shows that the edge detection counts it once, that the walk interval is placed after arm 2 rather than earlier, and that the request clears after it is served. Tick pulses spaced by idle cycles, and switch requests sent during yellow, separate a yellow timed in ticks from one timed in clock cycles or one cut short by a switch request.

// File: rtl/tlPkg.sv
package tlPkg;
  typedef enum logic [1:0] {
    PH_GREEN  = 2'd0,
    PH_LEFT   = 2'd1,
    PH_YELLOW = 2'd2,
    PH_WALK   = 2'd3
  } phase_e;

  typedef struct packed {
    logic clrTimer;
    logic clrPed;
  } ctrlStrobe_t;
endpackage

// File: rtl/tlDatapath.sv
module tlDatapath #(
  parameter int TIMER_W      = 2,
  parameter int YELLOW_TICKS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                pedButton,
  input  tlPkg::ctrlStrobe_t  strobe,
  output logic                yellowDone,
  output logic                pedPending
);
  localparam logic [TIMER_W-1:0] LAST_TICK = TIMER_W'(YELLOW_TICKS - 1);

  logic [TIMER_W-1:0] tickCount;
  logic               pedPrev;
  logic               pedEdge;

  assign pedEdge    = pedButton & ~pedPrev;
  assign yellowDone = tick && (tickCount == LAST_TICK);

  // Tick counter, held at zero outside yellow so it starts clean on entry.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) begin
      tickCount <= '0;
    end else if (tick && tickCount != LAST_TICK) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  // Request latch: a fresh edge wins over the clear from the serving phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pedPrev    <= 1'b0;
      pedPending <= 1'b0;
    end else begin
      pedPrev <= pedButton;
      if (pedEdge) begin
        pedPending <= 1'b1;
      end else if (strobe.clrPed) begin
        pedPending <= 1'b0;
      end
    end
  end

  assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= LAST_TICK);

  assert_ped_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!pedPending && !pedEdge) |=> !pedPending);
endmodule

// File: rtl/tlControl.sv
module tlControl #(
  parameter int NUM_ARMS = 2,
  parameter int ARM_W    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReq,
  input  logic                yellowDone,
  input  logic                pedPending,
  output tlPkg::ctrlStrobe_t  strobe,
  output tlPkg::phase_e       phase,
  output logic [ARM_W-1:0]    arm,
  output logic                phaseChange
);
  import tlPkg::*;

  localparam logic [ARM_W-1:0] LAST_ARM = ARM_W'(NUM_ARMS - 1);

  phase_e           nPhase;
  logic [ARM_W-1:0] nArm;
  logic             fromLeft;
  logic             nFromLeft;
  logic             clrPedNext;

  always_comb begin
    nPhase     = phase;
    nArm       = arm;
    nFromLeft  = fromLeft;
    clrPedNext = 1'b0;
    unique case (phase)
      PH_GREEN: if (swReq) begin
        nPhase    = PH_YELLOW;
        nFromLeft = 1'b0;
      end
      PH_LEFT: if (swReq) begin
        nPhase    = PH_YELLOW;
        nFromLeft = 1'b1;
      end
      PH_YELLOW: if (yellowDone) begin
        if (!fromLeft) begin
          nPhase = PH_LEFT;
        end else if (arm != LAST_ARM) begin
          nPhase = PH_GREEN;
          nArm   = arm + 1'b1;
        end else if (pedPending) begin
          nPhase = PH_WALK;
        end else begin
          nPhase = PH_GREEN;
          nArm   = '0;
        end
      end
      PH_WALK: if (swReq) begin
        nPhase     = PH_GREEN;
        nArm       = '0;
        clrPedNext = 1'b1;
      end
      default: nPhase = PH_GREEN;
    endcase
  end

  assign strobe.clrTimer = (phase != PH_YELLOW);
  assign strobe.clrPed   = clrPedNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_GREEN;
      arm         <= '0;
      fromLeft    <= 1'b0;
      phaseChange <= 1'b0;
    end else begin
      phase       <= nPhase;
      arm         <= nArm;
      fromLeft    <= nFromLeft;
      phaseChange <= (nPhase != phase) || (nArm != arm);
    end
  end

  assert_hold_no_sw_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_YELLOW && !swReq) |=> ($stable(phase) && $stable(arm)));

  assert_yellow_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_YELLOW && !yellowDone) |=> (phase == PH_YELLOW && $stable(arm)));

  assert_exit_via_yellow_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_GREEN || phase == PH_LEFT) && swReq) |=> (phase == PH_YELLOW && $stable(arm)));

  assert_walk_needs_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_WALK) |-> $past(pedPending));

  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    phaseChange |-> (phase != $past(phase) || arm != $past(arm)));
endmodule

// File: rtl/tlPhaseSeq.sv
module tlPhaseSeq #(
  parameter int NUM_ARMS     = 2,
  parameter int TIMER_W      = 2,
  parameter int YELLOW_TICKS = 2,
  localparam int ARM_W       = (NUM_ARMS > 2) ? $clog2(NUM_ARMS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                swReq,
  input  logic                pedButton,
  output logic [NUM_ARMS-1:0] lampRed,
  output logic [NUM_ARMS-1:0] lampYellow,
  output logic [NUM_ARMS-1:0] lampGreen,
  output logic [NUM_ARMS-1:0] lampLeft,
  output logic                walk,
  output logic [ARM_W-1:0]    activeArm,
  output logic [1:0]          phaseCode,
  output logic                phaseChange
);
  import tlPkg::*;

  ctrlStrobe_t      strobe;
  phase_e           phase;
  logic [ARM_W-1:0] arm;
  logic             yellowDone;
  logic             pedPending;

  tlControl #(.NUM_ARMS(NUM_ARMS), .ARM_W(ARM_W)) uControl (
    .clk(clk), .rstN(rstN), .swReq(swReq), .yellowDone(yellowDone),
    .pedPending(pedPending), .strobe(strobe), .phase(phase), .arm(arm),
    .phaseChange(phaseChange)
  );

  tlDatapath #(.TIMER_W(TIMER_W), .YELLOW_TICKS(YELLOW_TICKS)) uDatapath (
    .clk(clk), .rstN(rstN), .tick(tick), .pedButton(pedButton),
    .strobe(strobe), .yellowDone(yellowDone), .pedPending(pedPending)
  );

  for (genvar i = 0; i < NUM_ARMS; i++) begin : gArmLamps
    logic mine;
    assign mine          = (arm == ARM_W'(i)) && (phase != PH_WALK);
    assign lampGreen[i]  = mine && (phase == PH_GREEN);
    assign lampLeft[i]   = mine && (phase == PH_LEFT);
    assign lampYellow[i] = mine && (phase == PH_YELLOW);
    assign lampRed[i]    = !(lampGreen[i] || lampYellow[i]);
  end

  assign walk      = (phase == PH_WALK);
  assign activeArm = arm;
  assign phaseCode = phase;

  assert_single_go_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lampGreen | lampLeft));

  assert_others_red_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lampRed) >= NUM_ARMS - 1);

  assert_walk_all_red_R7: assert property (@(posedge clk) disable iff (!rstN)
    walk |-> (&lampRed && !(|lampLeft)));
endmodule

// File: tb/tb_tlPhaseSeq.sv
module tb_tlPhaseSeq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic       swReq;
  logic       pedButton;
  logic [1:0] lampRed, lampYellow, lampGreen, lampLeft;
  logic       walk;
  logic       activeArm;
  logic [1:0] phaseCode;
  logic       phaseChange;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  tlPhaseSeq dut (
    .clk(clk), .rstN(rstN), .tick(tick), .swReq(swReq), .pedButton(pedButton),
    .lampRed(lampRed), .lampYellow(lampYellow), .lampGreen(lampGreen),
    .lampLeft(lampLeft), .walk(walk), .activeArm(activeArm),
    .phaseCode(phaseCode), .phaseChange(phaseChange)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Expected outputs derived from the encodings in R9.
  task automatic checkState(string req, int expArm, int expPhase);
    logic [1:0] eR, eY, eG, eL;
    logic       eW;
    logic [9:0] act, exp;
    for (int i = 0; i < 2; i++) begin
      bit mine = (expArm == i) && (expPhase != 3);
      eG[i] = mine && expPhase == 0;
      eL[i] = mine && expPhase == 1;
      eY[i] = mine && expPhase == 2;
      eR[i] = !(eG[i] || eY[i]);
    end
    eW  = (expPhase == 3);
    exp = {eR, eY, eG, eL, eW, 1'(expArm)};
    act = {lampRed, lampYellow, lampGreen, lampLeft, walk, activeArm};
    checks++;
    if (act !== exp || phaseCode !== 2'(expPhase)) begin
      failures++;
      $display("FAIL %s: lamps/arm=%b phase=%0d expected lamps/arm=%b phase=%0d",
               req, act, phaseCode, exp, expPhase);
    end
  endtask

  task automatic checkPulse(string req, logic expVal);
    checks++;
    if (phaseChange !== expVal) begin
      failures++;
      $display("FAIL %s: phaseChange=%b expected %b", req, phaseChange, expVal);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSw();
    swReq = 1'b1;
    @(negedge clk);
    swReq = 1'b0;
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Leave a green/left interval and pass its yellow with spaced ticks.
  task automatic stepThroughYellow(string req, int arm, int nextArm, int nextPhase);
    pulseSw();
    checkState("R5 enter yellow", arm, 2);
    checkPulse("R8 pulse on yellow entry", 1'b1);
    idle(1);
    checkPulse("R8 pulse lasts one cycle", 1'b0);
    pulseTick();
    idle(4);
    checkState("R4 yellow after one tick", arm, 2);
    pulseTick();
    checkState(req, nextArm, nextPhase);
    checkPulse("R8 pulse on yellow exit", 1'b1);
  endtask

  task automatic testReset();
    rstN = 1'b0; tick = 1'b0; swReq = 1'b0; pedButton = 1'b0;
    idle(3);
    checkState("R1 during reset", 0, 0);
    rstN = 1'b1;
    idle(1);
    checkState("R1 after reset", 0, 0);
    checkPulse("R1 no pulse after reset", 1'b0);
  endtask

  task automatic testHoldWithoutSwitch();
    for (int k = 0; k < 4; k++) pulseTick();
    idle(3);
    checkState("R3 green held without swReq", 0, 0);
    checkPulse("R8 no pulse while held", 1'b0);
  endtask

  task automatic testYellowIgnoresSwitch();
    pulseSw();
    checkState("R5 green to yellow", 0, 2);
    pulseSw();
    pulseSw();
    checkState("R4 swReq ignored in yellow", 0, 2);
    pulseTick();
    pulseSw();
    checkState("R4 one tick not enough", 0, 2);
    pulseTick();
    checkState("R4 exit on second tick to left arrow", 0, 1);
    idle(5);
    checkState("R3 left arrow held", 0, 1);
    stepThroughYellow("R5 arm 2 green after arm 1 left", 0, 1, 0);
    stepThroughYellow("R5 arm 2 left after arm 2 green", 1, 1, 1);
    stepThroughYellow("R6 no walk without request", 1, 0, 0);
  endtask

  task automatic testPedestrian();
    pedButton = 1'b1;
    idle(4);
    pedButton = 1'b0;
    idle(1);
    checkState("R3 press does not interrupt green", 0, 0);
    stepThroughYellow("R6 no walk before arm 2", 0, 0, 1);
    stepThroughYellow("R5 arm 2 green", 0, 1, 0);
    stepThroughYellow("R5 arm 2 left", 1, 1, 1);
    stepThroughYellow("R6 walk inserted at cycle end", 1, 1, 3);
    idle(1);
    checkPulse("R8 walk pulse one cycle", 1'b0);
    for (int k = 0; k < 3; k++) pulseTick();
    idle(2);
    checkState("R7 walk held without swReq", 1, 3);
    pulseSw();
    checkState("R7 walk ends to arm 1 green", 0, 0);
    checkPulse("R8 pulse on walk exit", 1'b1);
    stepThroughYellow("R5 arm 1 left", 0, 0, 1);
    stepThroughYellow("R5 arm 2 green", 0, 1, 0);
    stepThroughYellow("R5 arm 2 left", 1, 1, 1);
    stepThroughYellow("R6 request cleared after walk", 1, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    testReset();
    testHoldWithoutSwitch();
    testYellowIgnoresSwitch();
    testPedestrian();
    report();
  end
endmodule